// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a CPU with a 16-bit address and a system bus with a wider address. The top four CPU address bits pick one of sixteen 4 KB pages. That page number, joined with a 4-bit map-select register, indexes a 256-entry table. The entry found there supplies the eight upper bits of the physical address. Any logical page can therefore sit on any 4 KB boundary of a 1 MB space. Sixteen complete address maps are held at once. A single register write swaps the whole map.

Each entry also carries a read-only flag and a dirty flag. A CPU write to a read-only page has its memory write strobe suppressed, and a one-cycle fault pulse is raised. An accepted CPU write marks its entry dirty. While a DMA master owns the bus, the translated outputs are released and CPU writes are ignored. DMA writes never touch the dirty flags.

Software reaches the table through four small I/O registers. A pointer register selects one entry by map and page. The entry's frame and flags are then written or read through that pointer. Reading the flags register clears the dirty bit.

Top module: `page_xlat`

## Requirements
- R1: `phys_hi` equals the frame field of the entry indexed by {map select, `cpu_page`}, combinationally in the same cycle.
- R2: After reset every entry of every map holds frame = page number (zero-extended), with the read-only and dirty flags clear; the map select and pointer registers are 0.
- R3: A write to register 0 changes the active map starting with the next cycle, so every page is translated through the new map.
- R4: I/O registers are selected by `io_sel`. Register 0 is the map select, held in `io_wdata[3:0]`; upper bits are ignored and read as 0. Register 1 is the pointer, with the map in bits [7:4] and the page in bits [3:0]. Register 2 is the frame of the pointed entry. Register 3 holds the flags: bit 0 is read-only (writable) and bit 1 is dirty (read only). Writes take effect at the clock edge, and `io_rdata` shows the current contents combinationally.
- R5: `mem_we` is high only when `cpu_wr` is high, `dma_act` is low and the addressed entry is not read-only.
- R6: A CPU write blocked by the read-only flag raises `wp_fault` in the following cycle, for exactly one cycle per blocked write.
- R7: An accepted CPU write sets the dirty bit of the addressed entry at the clock edge.
- R8: A read of register 3 with `io_rd` high clears the pointed entry's dirty bit at the clock edge. If an accepted CPU write hits the same entry in the same cycle, the bit ends up set.
- R9: While `dma_act` is high, `phys_oe` is low, `phys_hi` is 0 and `mem_we` is low.
- R10: A write with `dma_act` high sets no dirty bit and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_page | input | 4 | Top four CPU address bits |
| cpu_wr | input | 1 | CPU memory write request, one cycle per write |
| dma_act | input | 1 | DMA master owns the bus |
| io_wr | input | 1 | I/O register write strobe |
| io_rd | input | 1 | I/O register read strobe (clears dirty on register 3) |
| io_sel | input | 2 | I/O register select |
| io_wdata | input | 8 | I/O write data |
| phys_hi | output | 8 | Translated upper physical address bits |
| phys_oe | output | 1 | Enable for the translated address outputs |
| mem_we | output | 1 | Gated memory write strobe |
| wp_fault | output | 1 | One-cycle write-protect fault pulse |
| io_rdata | output | 8 | I/O read data |

## Verification
The hardest case to reach is a dirty-flag collision. Here a read-and-clear of an entry lands in the same cycle as an accepted CPU write to that same entry. To reach it, the stimulus first points the I/O pointer at the entry for the page the CPU is using in the active map. It then asserts `io_rd` on the flags register together with `cpu_wr` to that page, and reads the flags again to confirm the set won. DMA-time writes are issued to both a writable page and a read-only page, and the flags are read back afterwards, so that silent dirty or fault leakage shows up at the ports.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
    localparam int PAGE_W    = 4;
    localparam int MAP_W     = 4;
    localparam int FRAME_W   = 8;
    localparam int IO_W      = 8;
    localparam int IDX_W     = MAP_W + PAGE_W;
    localparam int NUM_ENT   = 1 << IDX_W;
    localparam int NUM_PAGES = 1 << PAGE_W;

    typedef enum logic [1:0] {
        IO_MAPSEL = 2'd0,
        IO_PTR    = 2'd1,
        IO_FRAME  = 2'd2,
        IO_FLAGS  = 2'd3
    } io_reg_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               ro;
    } entry_t;

    function automatic logic [IDX_W-1:0] make_idx(input logic [MAP_W-1:0] m,
                                                   input logic [PAGE_W-1:0] p);
        return {m, p};
    endfunction
endpackage

// File: rtl/pmap_regs.sv
module pmap_regs
    import pmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  io_reg_e          sel,
    input  logic [IO_W-1:0]  wdata,
    output logic [MAP_W-1:0] map_sel,
    output logic [IDX_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            map_sel <= '0;
            ptr     <= '0;
        end else if (io_wr) begin
            if (sel == IO_MAPSEL) map_sel <= wdata[MAP_W-1:0];
            if (sel == IO_PTR)    ptr     <= wdata[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/pmap_table.sv
module pmap_table
    import pmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_frame,
    input  logic               wr_ro,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               ro_in,
    input  logic [IDX_W-1:0]   xl_idx,
    output entry_t             xl_ent,
    output entry_t             io_ent
);
    entry_t tbl [NUM_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                tbl[i].frame <= FRAME_W'(i % NUM_PAGES);
                tbl[i].ro    <= 1'b0;
            end
        end else begin
            if (wr_frame) tbl[wr_idx].frame <= frame_in;
            if (wr_ro)    tbl[wr_idx].ro    <= ro_in;
        end
    end

    assign xl_ent = tbl[xl_idx];
    assign io_ent = tbl[wr_idx];
endmodule

// File: rtl/pmap_dirty.sv
module pmap_dirty
    import pmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_ENT-1:0] dirty_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dirty_q <= '0;
        end else begin
            if (clr_en) dirty_q[clr_idx] <= 1'b0;
            // a write landing on the entry being cleared keeps it marked
            if (set_en) dirty_q[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/page_xlat.sv
module page_xlat
    import pmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PAGE_W-1:0]  cpu_page,
    input  logic               cpu_wr,
    input  logic               dma_act,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [1:0]         io_sel,
    input  logic [IO_W-1:0]    io_wdata,
    output logic [FRAME_W-1:0] phys_hi,
    output logic               phys_oe,
    output logic               mem_we,
    output logic               wp_fault,
    output logic [IO_W-1:0]    io_rdata
);
    io_reg_e             sel_e;
    logic [MAP_W-1:0]    map_sel;
    logic [IDX_W-1:0]    ptr;
    logic [IDX_W-1:0]    xl_idx;
    entry_t              xl_ent;
    entry_t              io_ent;
    logic [NUM_ENT-1:0]  dirty_q;
    logic                cpu_req;
    logic                blocked;
    logic                fault_q;

    assign sel_e   = io_reg_e'(io_sel);
    assign xl_idx  = make_idx(map_sel, cpu_page);
    assign cpu_req = cpu_wr & ~dma_act;
    assign blocked = cpu_req & xl_ent.ro;

    pmap_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .sel     (sel_e),
        .wdata   (io_wdata),
        .map_sel (map_sel),
        .ptr     (ptr)
    );

    pmap_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_frame (io_wr && sel_e == IO_FRAME),
        .wr_ro    (io_wr && sel_e == IO_FLAGS),
        .wr_idx   (ptr),
        .frame_in (io_wdata[FRAME_W-1:0]),
        .ro_in    (io_wdata[0]),
        .xl_idx   (xl_idx),
        .xl_ent   (xl_ent),
        .io_ent   (io_ent)
    );

    pmap_dirty u_dirty (
        .clk     (clk),
        .rst     (rst),
        .set_en  (mem_we),
        .set_idx (xl_idx),
        .clr_en  (io_rd && sel_e == IO_FLAGS),
        .clr_idx (ptr),
        .dirty_q (dirty_q)
    );

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= blocked;
    end

    assign phys_hi  = dma_act ? '0 : xl_ent.frame;
    assign phys_oe  = ~dma_act;
    assign mem_we   = cpu_req & ~xl_ent.ro;
    assign wp_fault = fault_q;

    always_comb begin
        case (sel_e)
            IO_MAPSEL: io_rdata = IO_W'(map_sel);
            IO_PTR:    io_rdata = IO_W'(ptr);
            IO_FRAME:  io_rdata = IO_W'(io_ent.frame);
            default:   io_rdata = IO_W'({dirty_q[ptr], io_ent.ro});
        endcase
    end
endmodule

// File: rtl/pmap_chk.sv
module pmap_chk
    import pmap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [PAGE_W-1:0]  cpu_page,
    input logic               cpu_wr,
    input logic               dma_act,
    input logic               io_wr,
    input logic [1:0]         io_sel,
    input logic [MAP_W-1:0]   map_wdata,
    input logic [FRAME_W-1:0] phys_hi,
    input logic               phys_oe,
    input logic               mem_we,
    input logic               wp_fault,
    input logic [MAP_W-1:0]   map_sel,
    input logic [NUM_ENT-1:0] dirty_q,
    input logic [IDX_W-1:0]   xl_idx
);
    assert_dma_release_R9: assert property (@(posedge clk) disable iff (rst)
        dma_act |-> (!phys_oe && phys_hi == '0 && !mem_we));

    assert_we_gate_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cpu_wr && !dma_act));

    assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wp_fault == $past(cpu_wr && !dma_act && !mem_we)));

    assert_dirty_set_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_we) && !$past(rst)) |-> dirty_q[$past(xl_idx)]);

    assert_map_load_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(io_wr && io_sel == 2'd0) && !$past(rst)) |-> (map_sel == $past(map_wdata)));

    assert_reset_identity_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !dma_act) |-> (phys_hi == FRAME_W'(cpu_page)));
endmodule

bind page_xlat pmap_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_page  (cpu_page),
    .cpu_wr    (cpu_wr),
    .dma_act   (dma_act),
    .io_wr     (io_wr),
    .io_sel    (io_sel),
    .map_wdata (io_wdata[3:0]),
    .phys_hi   (phys_hi),
    .phys_oe   (phys_oe),
    .mem_we    (mem_we),
    .wp_fault  (wp_fault),
    .map_sel   (map_sel),
    .dirty_q   (dirty_q),
    .xl_idx    (xl_idx)
);

// File: tb/page_xlat_bench.sv
module page_xlat_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cpu_page = '0;
    logic       cpu_wr = 1'b0;
    logic       dma_act = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [1:0] io_sel = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] phys_hi;
    logic       phys_oe;
    logic       mem_we;
    logic       wp_fault;
    logic [7:0] io_rdata;

    always #5 clk = ~clk;

    page_xlat u_page_xlat (
        .clk(clk), .rst(rst), .cpu_page(cpu_page), .cpu_wr(cpu_wr),
        .dma_act(dma_act), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
        .io_wdata(io_wdata), .phys_hi(phys_hi), .phys_oe(phys_oe),
        .mem_we(mem_we), .wp_fault(wp_fault), .io_rdata(io_rdata)
    );

    typedef struct packed {
        logic [7:0] phys;
        logic       oe;
        logic       we;
        logic       flt;
        logic [7:0] rd;
        logic       chk_rd;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    logic [7:0] m_frame [256];
    logic       m_ro    [256];
    logic       m_dirty [256];
    logic [3:0] m_map;
    logic [7:0] m_ptr;
    logic       m_fault;

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_frame[i] = 8'(i % 16);
            m_ro[i]    = 1'b0;
            m_dirty[i] = 1'b0;
        end
        m_map = '0; m_ptr = '0; m_fault = 1'b0;
    endtask

    task automatic step(input logic dma, input logic [3:0] pg, input logic wr,
                        input logic iw, input logic ir, input logic [1:0] sel,
                        input logic [7:0] wd, input string tag, input logic chk);
        exp_t e;
        logic [7:0] idx;
        logic acc;
        @(posedge clk);
        #2;
        dma_act = dma; cpu_page = pg; cpu_wr = wr;
        io_wr = iw; io_rd = ir; io_sel = sel; io_wdata = wd;
        idx    = {m_map, pg};
        acc    = wr && !dma && !m_ro[idx];
        e.phys = dma ? 8'h00 : m_frame[idx];
        e.oe   = !dma;
        e.we   = acc;
        e.flt  = m_fault;
        case (sel)
            2'd0:    e.rd = {4'h0, m_map};
            2'd1:    e.rd = m_ptr;
            2'd2:    e.rd = m_frame[m_ptr];
            default: e.rd = {6'h00, m_dirty[m_ptr], m_ro[m_ptr]};
        endcase
        e.chk_rd = chk;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        // state after the coming edge
        m_fault = wr && !dma && m_ro[idx];
        if (ir && sel == 2'd3) m_dirty[m_ptr] = 1'b0;
        if (acc) m_dirty[idx] = 1'b1;
        if (iw) begin
            case (sel)
                2'd0:    m_map = wd[3:0];
                2'd1:    m_ptr = wd;
                2'd2:    m_frame[m_ptr] = wd;
                default: m_ro[m_ptr] = wd[0];
            endcase
        end
    endtask

    task automatic idle(input string tag);
        step(0, 4'h0, 0, 0, 0, 2'd0, 8'h00, tag, 0);
    endtask

    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = '{phys: phys_hi, oe: phys_oe, we: mem_we, flt: wp_fault,
                  rd: io_rdata, chk_rd: e.chk_rd};
            if (!e.chk_rd) a.rd = e.rd;
            n_vec++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual phys=%h oe=%b we=%b flt=%b rd=%h expected phys=%h oe=%b we=%b flt=%b rd=%h",
                         t, a.phys, a.oe, a.we, a.flt, a.rd, e.phys, e.oe, e.we, e.flt, e.rd);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        step(0, 4'h5, 0, 0, 0, 2'd0, 8'h00, "R2 map select zero after reset", 1);
        step(0, 4'h5, 0, 0, 0, 2'd1, 8'h00, "R2 pointer zero after reset", 1);
        for (int p = 0; p < 16; p++)
            step(0, 4'(p), 0, 0, 0, 2'd3, 8'h00, "R1 R2 identity map0, flags clear", 1);

        step(0, 4'h2, 0, 1, 0, 2'd1, 8'h32, "R4 load pointer", 1);
        step(0, 4'h2, 0, 1, 0, 2'd2, 8'hA7, "R4 load frame", 1);
        step(0, 4'h2, 0, 0, 0, 2'd2, 8'h00, "R4 frame readback", 1);
        step(0, 4'h2, 0, 1, 0, 2'd0, 8'h03, "R3 map write not yet active", 1);
        step(0, 4'h2, 0, 0, 0, 2'd0, 8'h00, "R1 R3 map3 page2 translated", 1);
        step(0, 4'h4, 0, 0, 0, 2'd0, 8'h00, "R1 R2 map3 page4 identity", 1);

        step(0, 4'h2, 1, 0, 0, 2'd3, 8'h00, "R7 accepted write strobe", 1);
        step(0, 4'h2, 0, 0, 1, 2'd3, 8'h00, "R7 R8 dirty visible then cleared", 1);
        step(0, 4'h2, 0, 0, 0, 2'd3, 8'h00, "R8 dirty cleared by read", 1);

        step(0, 4'h2, 0, 1, 0, 2'd3, 8'h01, "R4 set read-only", 1);
        step(0, 4'h2, 1, 0, 0, 2'd3, 8'h00, "R5 write to read-only blocked", 1);
        idle("R6 fault pulse after blocked write");
        idle("R6 fault lasts one cycle");
        step(0, 4'h2, 0, 0, 0, 2'd3, 8'h00, "R5 R7 blocked write leaves dirty clear", 1);
        step(0, 4'h2, 1, 0, 0, 2'd0, 8'h00, "R6 back-to-back blocked write 1", 0);
        step(0, 4'h2, 1, 0, 0, 2'd0, 8'h00, "R6 back-to-back blocked write 2", 0);
        idle("R6 second fault cycle");
        idle("R6 fault ends");

        step(1, 4'h2, 1, 0, 0, 2'd0, 8'h00, "R9 outputs released during DMA", 0);
        idle("R10 DMA write to read-only page no fault");
        step(0, 4'h4, 0, 1, 0, 2'd1, 8'h34, "R4 point at map3 page4", 1);
        step(1, 4'h4, 1, 0, 0, 2'd3, 8'h00, "R9 DMA write strobe suppressed", 1);
        step(0, 4'h4, 0, 0, 0, 2'd3, 8'h00, "R10 DMA write leaves dirty clear", 1);

        step(0, 4'h4, 1, 0, 1, 2'd3, 8'h00, "R8 clear and write same entry", 1);
        step(0, 4'h4, 0, 0, 0, 2'd3, 8'h00, "R8 set wins over clear", 1);

        step(0, 4'h2, 0, 1, 0, 2'd0, 8'hF0, "R3 R4 switch to map0 via low bits", 1);
        step(0, 4'h2, 0, 0, 0, 2'd0, 8'h00, "R3 R4 map0 page2 identity, upper bits dropped", 1);
        step(0, 4'h9, 0, 1, 0, 2'd0, 8'h03, "R3 map0 page9", 1);
        step(0, 4'h2, 0, 0, 0, 2'd0, 8'h00, "R3 map3 restored in one write", 1);
        idle("drain");
        @(posedge clk);
        #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule